// File: doc/BRIEF.md
# Indexed Codec Register Interface

This block is the byte-wide host side of an audio codec. Four direct ports sit behind a two-bit port select: an index pointer, a data window, a status byte and an unused programmed-I/O byte. The index pointer selects one of up to 32 indirect 8-bit registers, and the data window reads or writes the register it points at. Each indirect register has its own write rule. Some registers are read-only or reserved. The mode register accepts only its mode bit. The format register accepts a write only while a mode-change enable is open.

The block also holds a one-shot calibration busy flag, which is armed when the mode-change enable bit of the index rises. It keeps an interrupt flag that an external period-complete pulse sets and that software clears, and it drives that flag as a level interrupt. A handful of decoded control bits leave the block directly so that the playback and interrupt logic nearby can use them: playback enable, interrupt enable, wide addressing mode and the format byte.

Top module: `codec_regif`

## Requirements
- R1: Port select 0 is the index port, 1 the data window, 2 status and 3 the programmed-I/O byte. After reset the index holds 0x40. Indirect registers 2, 3, 4, 5, 18 and 19 hold 0x88, registers 6 and 7 hold 0x80, register 9 holds 0x08, register 12 holds 0x8A, and registers 25 and 26 hold 0xA0. Every other indirect register holds 0x00.
- R2: A write to the index port stores the byte with bit 7 forced to 0. A read of the index port returns the stored byte with bit 7 at 0. Index bit 6 is the mode-change enable (MCE).
- R3: The data window addresses indirect register index[3:0] while bit 6 of register 12 is 0, and index[4:0] while that bit is 1.
- R4: A write to register 8 is taken whole while MCE is 1. While MCE is 0 and bit 4 of register 24 is 1, the write takes bits 7:4 from the new byte and keeps bits 3:0. While both bits are 0, the write is dropped.
- R5: Writes to registers 11, 22, 27 and 29 leave them unchanged. A write to register 12 changes only its bit 6. A write to register 9 stores bit 5 as 0. All other registers store the written byte.
- R6: An index write that takes MCE from 0 to 1 while register 9 bits 4:3 are nonzero arms a one-count calibration flag. While the flag is armed, a data-window read of register 11 returns bit 5 set and consumes the count. Without arming, that bit reads 0.
- R7: Any write to the status port clears the interrupt flag and clears bits 4, 5 and 6 of register 24.
- R8: A data write to register 24 that takes its bit 4 from 1 to 0 clears the interrupt flag. A write that leaves bit 4 at 1 does not clear it.
- R9: A period_done pulse sets the interrupt flag and bit 4 of register 24 on the next edge. If a clearing event falls in the same cycle, the set wins. The irq output is the flag.
- R10: play_en follows bit 0 of register 9, irq_en follows bit 1 of register 10, wide_mode follows bit 6 of register 12, and fmt_byte is register 8. Each changes on the clock edge that takes the write.
- R11: Writes to the programmed-I/O port change nothing, and a read of that port returns 0x00. A read of the status port returns the interrupt flag in bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 2 | Direct port select |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe; only its side effect on the calibration flag is clocked |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte of the selected port, combinational |
| period_done | input | 1 | Playback period complete pulse |
| play_en | output | 1 | Playback enable |
| irq_en | output | 1 | Interrupt enable |
| wide_mode | output | 1 | 32-register addressing active |
| fmt_byte | output | 8 | Format register contents |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the format gate in all three of its states. A wrong gate would either let a locked format change or lose the kept low nibble under the partial enable. It checks the aliasing of the upper index bit in narrow mode and the reach to register 24 in wide mode; a fixed address width breaks one or the other. The calibration flag is exercised for one-shot consumption and for the case where it must not arm, since an edge-blind arm would report busy after every index write. For the interrupt, the bench covers clearing by the status port, clearing by a falling PI bit, a write that keeps PI set, and a set and a clear in the same cycle; a design with the wrong priority there would drop an interrupt.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int REG_W = 8;

   // indirect register numbers whose behaviour is special
   localparam int IX_FMT   = 8;
   localparam int IX_IFCFG = 9;
   localparam int IX_PINCTL = 10;
   localparam int IX_CALST = 11;
   localparam int IX_MODE  = 12;
   localparam int IX_RSV_A = 22;
   localparam int IX_RSV_B = 27;
   localparam int IX_RSV_C = 29;
   localparam int IX_ALTST = 24;
   localparam int MAX_IX   = 29;

   // bit positions that neighbours decode
   localparam int BIT_MCE     = 6;
   localparam int BIT_WIDE    = 6;
   localparam int BIT_PMCE    = 4;
   localparam int BIT_PI      = 4;
   localparam int BIT_CI      = 5;
   localparam int BIT_TI      = 6;
   localparam int BIT_CALBUSY = 5;
   localparam int BIT_PEN     = 0;
   localparam int BIT_IEN     = 1;
   localparam int BIT_CFG_RSV = 5;

   typedef enum logic [1:0] {
      PORT_INDEX  = 2'd0,
      PORT_DATA   = 2'd1,
      PORT_STATUS = 2'd2,
      PORT_PIO    = 2'd3
   } port_e;

   function automatic logic [REG_W-1:0] ireg_reset(input int ix);
      case (ix)
         2, 3, 4, 5, 18, 19: return 8'h88;
         6, 7:               return 8'h80;
         IX_IFCFG:           return 8'h08;
         IX_MODE:            return 8'h8A;
         25, 26:             return 8'hA0;
         default:            return 8'h00;
      endcase
   endfunction

   // value a data-window write leaves in register ix
   function automatic logic [REG_W-1:0] ireg_apply_write(
      input int               ix,
      input logic [REG_W-1:0] old_v,
      input logic [REG_W-1:0] new_v,
      input logic             mce,
      input logic             pmce);
      logic [REG_W-1:0] r;
      r = new_v;
      case (ix)
         IX_FMT: begin
            if (mce)       r = new_v;
            else if (pmce) r = {new_v[7:4], old_v[3:0]};
            else           r = old_v;
         end
         IX_IFCFG: r[BIT_CFG_RSV] = 1'b0;
         IX_MODE: begin
            r = old_v;
            r[BIT_WIDE] = new_v[BIT_WIDE];
         end
         IX_CALST, IX_RSV_A, IX_RSV_B, IX_RSV_C: r = old_v;
         default: r = new_v;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/codec_index_unit.sv
module codec_index_unit
   import codec_regif_pkg::*;
#(
   parameter int CAL_LOAD = 1,
   parameter int CAL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             cal_arm_ok,
   input  logic             cal_rd,
   output logic [REG_W-1:0] idx_q,
   output logic             cal_busy
);
   timeunit 1ns;
   timeprecision 1ps;

   generate
      if (CAL_W < 1 || CAL_LOAD < 0 || CAL_LOAD >= (1 << CAL_W)) begin : g_bad_cal
         $error("codec_index_unit: CAL_LOAD does not fit in CAL_W bits");
      end
   endgenerate

   logic mce_rise;
   assign mce_rise = idx_wr && !idx_q[BIT_MCE] && wdata[BIT_MCE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= 8'h40;
      end else if (idx_wr) begin
         idx_q <= {1'b0, wdata[REG_W-2:0]};
      end
   end

   generate
      if (CAL_LOAD > 0) begin : g_cal
         logic [CAL_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (mce_rise && cal_arm_ok) begin
               cnt_q <= CAL_W'(CAL_LOAD);
            end else if (cal_rd && cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign cal_busy = (cnt_q != '0);
      end else begin : g_nocal
         assign cal_busy = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/codec_ireg_bank.sv
module codec_ireg_bank
   import codec_regif_pkg::*;
#(
   parameter int NUM_REGS = 32,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            dwr,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [REG_W-1:0]                wdata,
   input  logic                            mce,
   input  logic                            status_wr,
   input  logic                            period_done,
   output logic [NUM_REGS-1:0][REG_W-1:0]  regs_q
);
   timeunit 1ns;
   timeprecision 1ps;

   logic pmce;
   assign pmce = regs_q[IX_ALTST][BIT_PMCE];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         logic [REG_W-1:0] q;
         logic [REG_W-1:0] nxt;

         always_comb begin
            nxt = q;
            if (dwr && addr == ADDR_W'(g)) begin
               nxt = ireg_apply_write(g, q, wdata, mce, pmce);
            end
            if (g == IX_ALTST) begin
               if (status_wr) begin
                  nxt[BIT_PI] = 1'b0;
                  nxt[BIT_CI] = 1'b0;
                  nxt[BIT_TI] = 1'b0;
               end
               if (period_done) begin
                  nxt[BIT_PI] = 1'b1;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= ireg_reset(g);
            else        q <= nxt;
         end

         assign regs_q[g] = q;
      end
   endgenerate
endmodule

// File: rtl/codec_irq_unit.sv
module codec_irq_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic period_done,
   input  logic status_wr,
   input  logic pi_fall,
   output logic int_q
);
   timeunit 1ns;
   timeprecision 1ps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      int_q <= 1'b0;
      else if (period_done)            int_q <= 1'b1;
      else if (status_wr || pi_fall)   int_q <= 1'b0;
   end
endmodule

// File: rtl/codec_regif.sv
module codec_regif
   import codec_regif_pkg::*;
#(
   parameter int NUM_REGS    = 32,
   parameter int NARROW_REGS = 16,
   parameter int DATA_W      = 8,
   parameter int CAL_LOAD    = 1,
   parameter int CAL_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        port_sel,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              period_done,
   output logic              play_en,
   output logic              irq_en,
   output logic              wide_mode,
   output logic [DATA_W-1:0] fmt_byte,
   output logic              irq
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int ADDR_W   = $clog2(NUM_REGS);
   localparam int NARROW_W = $clog2(NARROW_REGS);

   generate
      if (DATA_W != REG_W) begin : g_bad_width
         $error("codec_regif: DATA_W must equal the register width");
      end
      if ((1 << ADDR_W) != NUM_REGS || NUM_REGS <= MAX_IX || ADDR_W > BIT_MCE) begin : g_bad_depth
         $error("codec_regif: NUM_REGS must be a power of two that holds the map and fits below MCE");
      end
      if ((1 << NARROW_W) != NARROW_REGS || NARROW_REGS <= IX_MODE || NARROW_REGS >= NUM_REGS) begin : g_bad_narrow
         $error("codec_regif: NARROW_REGS must be a power of two between the mode register and NUM_REGS");
      end
   endgenerate

   port_e                          port;
   logic [REG_W-1:0]               idx_q;
   logic                           cal_busy;
   logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
   logic [ADDR_W-1:0]              iaddr;
   logic                           wide, mce, int_q;
   logic                           idx_wr, dwr, status_wr, pi_fall, at_calst, cal_rd;

   assign port      = port_e'(port_sel);
   assign idx_wr    = wr_en && port == PORT_INDEX;
   assign dwr       = wr_en && port == PORT_DATA;
   assign status_wr = wr_en && port == PORT_STATUS;
   assign wide      = regs_q[IX_MODE][BIT_WIDE];
   assign mce       = idx_q[BIT_MCE];

   always_comb begin
      if (wide) iaddr = idx_q[ADDR_W-1:0];
      else      iaddr = ADDR_W'(idx_q[NARROW_W-1:0]);
   end

   assign at_calst = (iaddr == ADDR_W'(IX_CALST));
   assign cal_rd   = rd_en && port == PORT_DATA && at_calst;
   assign pi_fall  = dwr && iaddr == ADDR_W'(IX_ALTST)
                     && regs_q[IX_ALTST][BIT_PI] && !wdata[BIT_PI];

   codec_index_unit #(.CAL_LOAD(CAL_LOAD), .CAL_W(CAL_W)) u_index (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx_wr     (idx_wr),
      .wdata      (wdata),
      .cal_arm_ok (regs_q[IX_IFCFG][4:3] != 2'b00),
      .cal_rd     (cal_rd),
      .idx_q      (idx_q),
      .cal_busy   (cal_busy)
   );

   codec_ireg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .dwr         (dwr),
      .addr        (iaddr),
      .wdata       (wdata),
      .mce         (mce),
      .status_wr   (status_wr),
      .period_done (period_done),
      .regs_q      (regs_q)
   );

   codec_irq_unit u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .period_done (period_done),
      .status_wr   (status_wr),
      .pi_fall     (pi_fall),
      .int_q       (int_q)
   );

   always_comb begin
      rdata = '0;
      case (port)
         PORT_INDEX:  rdata = idx_q & 8'h7F;
         PORT_DATA: begin
            rdata = regs_q[iaddr];
            if (at_calst && cal_busy) rdata[BIT_CALBUSY] = 1'b1;
         end
         PORT_STATUS: rdata = {{(REG_W-1){1'b0}}, int_q};
         PORT_PIO:    rdata = '0;
         default:     rdata = '0;
      endcase
   end

   assign play_en   = regs_q[IX_IFCFG][BIT_PEN];
   assign irq_en    = regs_q[IX_PINCTL][BIT_IEN];
   assign wide_mode = wide;
   assign fmt_byte  = regs_q[IX_FMT];
   assign irq       = int_q;
endmodule

// File: rtl/codec_regif_chk.sv
module codec_regif_chk
   import codec_regif_pkg::*;
#(
   parameter int NUM_REGS = 32,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [1:0]                      port_sel,
   input logic                            wr_en,
   input logic                            rd_en,
   input logic [REG_W-1:0]                wdata,
   input logic [REG_W-1:0]                rdata,
   input logic                            period_done,
   input logic [REG_W-1:0]                fmt_byte,
   input logic                            irq,
   input logic [ADDR_W-1:0]               iaddr,
   input logic                            mce,
   input logic                            cal_busy,
   input logic [NUM_REGS-1:0][REG_W-1:0]  regs_q
);
   timeunit 1ns;
   timeprecision 1ps;

   logic dwr, pmce;
   assign dwr  = wr_en && port_sel == 2'd1;
   assign pmce = regs_q[IX_ALTST][BIT_PMCE];

   p_index_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && port_sel == 2'd0 |-> rdata[7] == 1'b0);

   p_fmt_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dwr && iaddr == ADDR_W'(IX_FMT) && !mce && !pmce |=> $stable(fmt_byte));

   p_fmt_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dwr && iaddr == ADDR_W'(IX_FMT) && !mce && pmce
      |=> fmt_byte == {$past(wdata[7:4]), $past(fmt_byte[3:0])});

   p_calst_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dwr && iaddr == ADDR_W'(IX_CALST) |=> $stable(regs_q[IX_CALST]));

   p_mode_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dwr && iaddr == ADDR_W'(IX_MODE)
      |=> regs_q[IX_MODE][BIT_WIDE] == $past(wdata[BIT_WIDE])
          && regs_q[IX_MODE][7] == $past(regs_q[IX_MODE][7])
          && regs_q[IX_MODE][5:0] == $past(regs_q[IX_MODE][5:0]));

   p_cal_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && port_sel == 2'd1 && iaddr == ADDR_W'(IX_CALST) && cal_busy |-> rdata[BIT_CALBUSY]);

   p_status_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && port_sel == 2'd2 && !period_done |=> !irq);

   p_period_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      period_done |=> irq && regs_q[IX_ALTST][BIT_PI]);

   p_status_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && port_sel == 2'd2 |-> rdata == {7'b0, irq});
endmodule

bind codec_regif codec_regif_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .port_sel    (port_sel),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .wdata       (wdata),
   .rdata       (rdata),
   .period_done (period_done),
   .fmt_byte    (fmt_byte),
   .irq         (irq),
   .iaddr       (iaddr),
   .mce         (mce),
   .cal_busy    (cal_busy),
   .regs_q      (regs_q)
);

// File: tb/codec_regif_test.sv
module codec_regif_test;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] port_sel = 2'd0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       period_done = 1'b0;
   logic [7:0] rdata, fmt_byte;
   logic       play_en, irq_en, wide_mode, irq;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  live = 0;
   bit  finished = 0;

   always #2.5 clk = ~clk;

   codec_regif uut (
      .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .period_done(period_done), .play_en(play_en),
      .irq_en(irq_en), .wide_mode(wide_mode), .fmt_byte(fmt_byte), .irq(irq)
   );

   // ---------------- behavioural reference ----------------
   int m_reg[32];
   int m_idx;
   int m_cal;
   bit m_int;

   function automatic int m_rst_val(int i);
      if (i inside {2, 3, 4, 5, 18, 19}) return 'h88;
      if (i inside {6, 7}) return 'h80;
      if (i == 9) return 'h08;
      if (i == 12) return 'h8A;
      if (i inside {25, 26}) return 'hA0;
      return 0;
   endfunction

   task automatic m_reset();
      for (int i = 0; i < 32; i++) m_reg[i] = m_rst_val(i);
      m_idx = 'h40;
      m_cal = 0;
      m_int = 0;
   endtask

   function automatic int m_iaddr();
      return ((m_reg[12] & 'h40) != 0) ? (m_idx & 31) : (m_idx & 15);
   endfunction

   function automatic int m_rdata();
      int a, v;
      case (port_sel)
         2'd0: return m_idx & 'h7F;
         2'd1: begin
            a = m_iaddr();
            v = m_reg[a];
            if (a == 11 && m_cal > 0) v = v | 'h20;
            return v;
         end
         2'd2: return int'(m_int);
         default: return 0;
      endcase
   endfunction

   task automatic m_step();
      int a, d, old24;
      a = m_iaddr();
      d = int'(wdata);
      old24 = m_reg[24];
      if (wr_en) begin
         case (port_sel)
            2'd0: begin
               if ((m_idx & 'h40) == 0 && (d & 'h40) != 0 && (m_reg[9] & 'h18) != 0) m_cal = 1;
               m_idx = d & 'h7F;
            end
            2'd1: begin
               case (a)
                  8: begin
                     if ((m_idx & 'h40) != 0) m_reg[8] = d;
                     else if ((m_reg[24] & 'h10) != 0) m_reg[8] = (d & 'hF0) | (m_reg[8] & 'h0F);
                  end
                  9: m_reg[9] = d & 'hDF;
                  11, 22, 27, 29: ;
                  12: m_reg[12] = (m_reg[12] & 'hBF) | (d & 'h40);
                  24: begin
                     if ((old24 & 'h10) != 0 && (d & 'h10) == 0) m_int = 0;
                     m_reg[24] = d;
                  end
                  default: m_reg[a] = d;
               endcase
            end
            2'd2: begin
               m_int = 0;
               m_reg[24] = m_reg[24] & 'h8F;
            end
            default: ;
         endcase
      end
      if (rd_en && port_sel == 2'd1 && a == 11 && m_cal > 0) m_cal = m_cal - 1;
      if (period_done) begin
         m_int = 1;
         m_reg[24] = m_reg[24] | 'h10;
      end
   endtask

   initial m_reset();

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else m_step();
   end

   // ---------------- checking ----------------
   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every output with the reference each cycle
   always @(negedge clk) begin
      if (live) begin
         chk("R4 fmt_byte", int'(fmt_byte), m_reg[8]);
         chk("R10 play_en", int'(play_en), m_reg[9] & 1);
         chk("R10 irq_en", int'(irq_en), (m_reg[10] >> 1) & 1);
         chk("R3 wide_mode", int'(wide_mode), (m_reg[12] >> 6) & 1);
         chk("R9 irq", int'(irq), int'(m_int));
         chk("R1 rdata", int'(rdata), m_rdata());
      end
   end

   task automatic bus_wr(input logic [1:0] p, input logic [7:0] d);
      port_sel = p; wdata = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] p, output int v);
      port_sel = p; rd_en = 1'b1;
      #2;
      v = int'(rdata);
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic pulse_done();
      period_done = 1'b1;
      @(posedge clk); #1;
      period_done = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      live = 1;
      @(posedge clk); #1;

      // R1 reset state
      bus_rd(2'd0, v); chk("R1 index reset", v, 'h40);
      bus_rd(2'd1, v); chk("R1 reg0 reset", v, 'h00);
      bus_wr(2'd0, 8'h4C); bus_rd(2'd1, v); chk("R1 reg12 reset", v, 'h8A);
      bus_wr(2'd0, 8'h49); bus_rd(2'd1, v); chk("R1 reg9 reset", v, 'h08);
      bus_wr(2'd0, 8'h42); bus_rd(2'd1, v); chk("R1 reg2 reset", v, 'h88);

      // R2 index bit 7
      bus_wr(2'd0, 8'hC3); bus_rd(2'd0, v); chk("R2 index msb", v, 'h43);

      // R5 reg9 bit5, R10 play_en / irq_en
      bus_wr(2'd0, 8'h49); bus_wr(2'd1, 8'h29);
      bus_rd(2'd1, v); chk("R5 reg9 bit5", v, 'h09);
      chk("R10 play_en on", int'(play_en), 1);
      bus_wr(2'd0, 8'h4A); bus_wr(2'd1, 8'h02);
      chk("R10 irq_en on", int'(irq_en), 1);

      // R3 narrow aliasing: index 0x58 reaches reg 8
      bus_wr(2'd0, 8'h58); bus_wr(2'd1, 8'h35);
      chk("R3 narrow alias to fmt", int'(fmt_byte), 'h35);

      // R5 mode register, only bit 6 writable
      bus_wr(2'd0, 8'h4C); bus_wr(2'd1, 8'hFF);
      bus_rd(2'd1, v); chk("R5 reg12 bit6 only", v, 'hCA);
      chk("R10 wide_mode on", int'(wide_mode), 1);

      // R3 wide: index 0x58 reaches reg 24
      bus_wr(2'd0, 8'h58); bus_wr(2'd1, 8'h10);
      bus_rd(2'd1, v); chk("R3 wide reaches reg24", v, 'h10);
      chk("R3 fmt untouched", int'(fmt_byte), 'h35);

      // R4 partial enable keeps low nibble
      bus_wr(2'd0, 8'h08); bus_wr(2'd1, 8'hA7);
      chk("R4 pmce nibble", int'(fmt_byte), 'hA5);
      bus_wr(2'd0, 8'h18); bus_wr(2'd1, 8'h00);
      bus_wr(2'd0, 8'h08); bus_wr(2'd1, 8'hFF);
      chk("R4 locked format", int'(fmt_byte), 'hA5);

      // R5 reserved and read-only registers
      bus_wr(2'd0, 8'h16); bus_wr(2'd1, 8'h55); bus_rd(2'd1, v); chk("R5 reg22 ignored", v, 0);
      bus_wr(2'd0, 8'h1B); bus_wr(2'd1, 8'h55); bus_rd(2'd1, v); chk("R5 reg27 ignored", v, 0);
      bus_wr(2'd0, 8'h1D); bus_wr(2'd1, 8'h55); bus_rd(2'd1, v); chk("R5 reg29 ignored", v, 0);
      bus_wr(2'd0, 8'h0B); bus_wr(2'd1, 8'hFF); bus_rd(2'd1, v); chk("R5 reg11 read-only", v, 0);

      // R6 calibration flag, one shot
      bus_wr(2'd0, 8'h4B);
      bus_rd(2'd1, v); chk("R6 cal busy", v, 'h20);
      bus_rd(2'd1, v); chk("R6 cal consumed", v, 'h00);
      bus_wr(2'd0, 8'h49); bus_wr(2'd1, 8'h01);
      bus_wr(2'd0, 8'h0B); bus_wr(2'd0, 8'h4B);
      bus_rd(2'd1, v); chk("R6 no arm without cal mode", v, 'h00);

      // R9 set, R7 status clear
      bus_wr(2'd0, 8'h58); bus_wr(2'd1, 8'h6F);
      pulse_done();
      chk("R9 irq set", int'(irq), 1);
      bus_rd(2'd2, v); chk("R11 status read", v, 'h01);
      bus_rd(2'd1, v); chk("R9 PI set", v, 'h7F);
      bus_wr(2'd2, 8'h00);
      chk("R7 irq cleared", int'(irq), 0);
      bus_rd(2'd1, v); chk("R7 reg24 flags cleared", v, 'h0F);

      // R8 PI falling edge
      pulse_done();
      bus_wr(2'd1, 8'h1F);
      chk("R8 PI kept, irq stays", int'(irq), 1);
      bus_wr(2'd1, 8'h0F);
      chk("R8 PI fall clears irq", int'(irq), 0);

      // R9 set wins over clear in the same cycle
      port_sel = 2'd2; wdata = 8'h00; wr_en = 1'b1; period_done = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0; period_done = 1'b0;
      chk("R9 set wins", int'(irq), 1);
      bus_rd(2'd1, v); chk("R9 PI after race", v, 'h1F);

      // R11 programmed-I/O port
      bus_wr(2'd3, 8'hFF);
      bus_rd(2'd3, v); chk("R11 pio reads zero", v, 0);
      bus_rd(2'd2, v); chk("R11 pio write ignored", v, 'h01);

      // mixed traffic against the reference
      for (int k = 0; k < 4000; k++) begin
         int r;
         r = $urandom_range(0, 99);
         wr_en = 1'b0; rd_en = 1'b0;
         port_sel = 2'($urandom_range(0, 3));
         wdata = 8'($urandom_range(0, 255));
         if (r < 35) wr_en = 1'b1;
         else if (r < 70) rd_en = 1'b1;
         period_done = ($urandom_range(0, 15) == 0);
         @(posedge clk); #1;
      end
      wr_en = 1'b0; rd_en = 1'b0; period_done = 1'b0;
      @(posedge clk); #1;

      live = 0;
      finished = 1;
      summary();
      $finish;
   end
endmodule